// File: doc/BRIEF.md
# Parallel Port Controller with Single-Bit Command

A host-attached parallel I/O controller with three ports of eight lines each, called A, B and C. Port C is handled as two independent nibbles: the upper half joins port A's group and the lower half joins port B's group. The host uses a synchronous 8-bit bus with a chip select, read and write strobes, and a 2-bit register address. Each port has an output latch, an output-enable vector and a pin input. Writes take effect at the rising clock edge where the chip select and write strobe are both high. Read data is combinational from the current state and pins.

One register address takes two kinds of command, chosen by bit 7 of the written byte. A configuration word sets the mode field of each group and the direction of each of the four port groups. It also clears every output latch. A single-bit command forces one port C latch bit high or low and leaves the configuration alone. Only simple unhandshaked transfers are implemented. The handshake and bidirectional mode codes are decoded and stored so that they can be read back, but they change nothing else.

Top module: `pp_ctrl`

## Requirements
- R1: While the active-low reset is asserted, and after it is released, all output enables are 0 (every group is an input), all output latches are 0 and both mode fields are 0.
- R2: A write with the register address at 0, 1 or 2 loads the write byte into the port A, port B or port C output latch respectively. The latch appears on that port's output lines after the clock edge.
- R3: A write to address 3 with bit 7 = 1 is a configuration word. Its fields are:
  - bits 6:5: group A mode
  - bit 4: port A direction
  - bit 3: upper port C nibble direction
  - bit 2: group B mode
  - bit 1: port B direction
  - bit 0: lower port C nibble direction

  For each direction bit, 1 = input and drives that group's output enables to 0; 0 = output and drives them to all ones.
- R4: Every configuration word clears the port A, B and C output latches to 0.
- R5: A write to address 3 with bit 7 = 0 is a single-bit command. It sets port C latch bit number wdata[3:1] to wdata[0] and leaves every other latch bit unchanged.
- R6: A single-bit command leaves the configuration unchanged, and bits 6:4 of that command have no effect.
- R7: A read of a port returns its output latch when the port is an output and its pin inputs when it is an input. For port C this choice is made separately for each nibble.
- R8: A read of address 3 returns the configuration as {1, group A mode[1:0], A dir, upper C dir, group B mode, B dir, lower C dir}.
- R9: With chip select low, the write strobe changes no latch and no configuration, and the read data is 0.
- R10: The read data is 0 in any cycle in which chip select and read strobe are not both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_cs | input | 1 | Chip select, active high |
| bus_rd | input | 1 | Read strobe, active high |
| bus_wr | input | 1 | Write strobe, active high |
| bus_addr | input | 2 | Register address: 0 A, 1 B, 2 C, 3 command |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| pa_i | input | 8 | Port A pin inputs |
| pa_o | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enables |
| pb_i | input | 8 | Port B pin inputs |
| pb_o | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enables |
| pc_i | input | 8 | Port C pin inputs |
| pc_o | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enables |

## Verification
The assertions check four rules on every cycle:
- a single-bit command leaves the configuration unchanged and flips at most one port C latch bit;
- a configuration word always leaves all latches at zero;
- a cycle with chip select low changes no state;
- the read bus is quiet whenever no read is selected.

Some behaviours only the bench's scenarios can show: the exact field positions of the configuration word, the per-nibble choice between latch and pin on port C reads, the readback format, and the fact that the ignored bits 6:4 really have no effect. The bench shows these by comparing every output against its own reference model on every clock, and through directed transactions with hand-computed values.

// File: rtl/pp_pkg.sv
package pp_pkg;
    localparam int PP_W = 8;

    typedef enum logic [1:0] {
        SEL_A   = 2'd0,
        SEL_B   = 2'd1,
        SEL_C   = 2'd2,
        SEL_CMD = 2'd3
    } pp_sel_e;

    typedef struct packed {
        logic [1:0] mode_a;
        logic       in_a;
        logic       in_cu;
        logic       mode_b;
        logic       in_b;
        logic       in_cl;
    } pp_cfg_t;

    localparam pp_cfg_t CFG_RESET = '{mode_a: 2'b00, in_a: 1'b1, in_cu: 1'b1,
                                      mode_b: 1'b0, in_b: 1'b1, in_cl: 1'b1};
endpackage

// File: rtl/pp_regs.sv
module pp_regs
    import pp_pkg::*;
#(
    parameter int PW = PP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  pp_sel_e       sel,
    input  logic [PW-1:0] wdata,
    output pp_cfg_t       cfg_q_o,
    output logic [PW-1:0] la_q_o,
    output logic [PW-1:0] lb_q_o,
    output logic [PW-1:0] lc_q_o
);
    localparam int SELW = $clog2(PW);

    typedef struct packed {
        pp_cfg_t       cfg;
        logic [PW-1:0] la;
        logic [PW-1:0] lb;
        logic [PW-1:0] lc;
    } regs_t;

    regs_t st_d, st_q;
    logic  cmd_wr, is_cfg_word;
    logic [SELW-1:0] bit_idx;

    always_comb begin
        st_d        = st_q;
        cmd_wr      = wr_en && (sel == SEL_CMD);
        is_cfg_word = wdata[7];
        bit_idx     = wdata[SELW:1];
        if (wr_en) begin
            unique case (sel)
                SEL_A:   st_d.la = wdata;
                SEL_B:   st_d.lb = wdata;
                SEL_C:   st_d.lc = wdata;
                default: begin
                    if (is_cfg_word) begin
                        st_d.cfg = pp_cfg_t'(wdata[6:0]);
                        st_d.la  = '0;
                        st_d.lb  = '0;
                        st_d.lc  = '0;
                    end else begin
                        st_d.lc[bit_idx] = wdata[0];
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cfg: CFG_RESET, la: '0, lb: '0, lc: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_q_o = st_q.cfg;
    assign la_q_o  = st_q.la;
    assign lb_q_o  = st_q.lb;
    assign lc_q_o  = st_q.lc;

    AST_BIT_CMD_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !is_cfg_word) |=> $stable(st_q.cfg)); // R6

    AST_BIT_CMD_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !is_cfg_word) |=> ($countones(st_q.lc ^ $past(st_q.lc)) <= 1)
            && $stable(st_q.la) && $stable(st_q.lb)); // R5

    AST_CFG_CLEARS_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && is_cfg_word) |=> (st_q.la == '0 && st_q.lb == '0 && st_q.lc == '0)); // R4

    AST_IDLE_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q)); // R9
endmodule

// File: rtl/pp_rd_mux.sv
module pp_rd_mux
    import pp_pkg::*;
#(
    parameter int PW = PP_W
) (
    input  logic          rd_en,
    input  pp_sel_e       sel,
    input  pp_cfg_t       cfg,
    input  logic [PW-1:0] la,
    input  logic [PW-1:0] lb,
    input  logic [PW-1:0] lc,
    input  logic [PW-1:0] pa_i,
    input  logic [PW-1:0] pb_i,
    input  logic [PW-1:0] pc_i,
    output logic [PW-1:0] rdata
);
    localparam int HW = PW / 2;

    logic [PW-1:0] c_view;

    assign c_view = {cfg.in_cu ? pc_i[PW-1:HW] : lc[PW-1:HW],
                     cfg.in_cl ? pc_i[HW-1:0]  : lc[HW-1:0]};

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (sel)
                SEL_A:   rdata = cfg.in_a ? pa_i : la;
                SEL_B:   rdata = cfg.in_b ? pb_i : lb;
                SEL_C:   rdata = c_view;
                default: rdata = PW'({1'b1, cfg});
            endcase
        end
    end
endmodule

// File: rtl/pp_ctrl.sv
module pp_ctrl
    import pp_pkg::*;
#(
    parameter int PW = PP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_cs,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic [1:0]    bus_addr,
    input  logic [PW-1:0] bus_wdata,
    output logic [PW-1:0] bus_rdata,
    input  logic [PW-1:0] pa_i,
    output logic [PW-1:0] pa_o,
    output logic [PW-1:0] pa_oe,
    input  logic [PW-1:0] pb_i,
    output logic [PW-1:0] pb_o,
    output logic [PW-1:0] pb_oe,
    input  logic [PW-1:0] pc_i,
    output logic [PW-1:0] pc_o,
    output logic [PW-1:0] pc_oe
);
    localparam int HW = PW / 2;

    pp_sel_e       sel;
    logic          wr_en, rd_en;
    pp_cfg_t       cfg;
    logic [PW-1:0] la, lb, lc;

    assign sel   = pp_sel_e'(bus_addr);
    assign wr_en = bus_cs && bus_wr;
    assign rd_en = bus_cs && bus_rd;

    pp_regs #(.PW(PW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel), .wdata(bus_wdata),
        .cfg_q_o(cfg), .la_q_o(la), .lb_q_o(lb), .lc_q_o(lc)
    );

    pp_rd_mux #(.PW(PW)) u_rd (
        .rd_en(rd_en), .sel(sel), .cfg(cfg), .la(la), .lb(lb), .lc(lc),
        .pa_i(pa_i), .pb_i(pb_i), .pc_i(pc_i), .rdata(bus_rdata)
    );

    assign pa_o  = la;
    assign pb_o  = lb;
    assign pc_o  = lc;
    assign pa_oe = {PW{~cfg.in_a}};
    assign pb_oe = {PW{~cfg.in_b}};
    assign pc_oe = {{HW{~cfg.in_cu}}, {HW{~cfg.in_cl}}};

    AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_cs && bus_rd) |-> (bus_rdata == '0)); // R10
endmodule

// File: tb/tb_pp_ctrl.sv
module tb_pp_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_cs = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic [7:0] pa_i = 8'h00, pb_i = 8'h00, pc_i = 8'h00;
    logic [7:0] pa_o, pa_oe, pb_o, pb_oe, pc_o, pc_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    logic [1:0] m_ma;
    logic       m_mb, m_ia, m_icu, m_ib, m_icl;
    logic [7:0] m_la, m_lb, m_lc;

    always #2.5 clk = ~clk;

    pp_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pa_i(pa_i), .pa_o(pa_o), .pa_oe(pa_oe),
        .pb_i(pb_i), .pb_o(pb_o), .pb_oe(pb_oe),
        .pc_i(pc_i), .pc_o(pc_o), .pc_oe(pc_oe)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] model_rd();
        logic [7:0] r;
        r = 8'h00;
        if (bus_cs && bus_rd) begin
            case (bus_addr)
                2'd0: r = m_ia ? pa_i : m_la;
                2'd1: r = m_ib ? pb_i : m_lb;
                2'd2: r = {m_icu ? pc_i[7:4] : m_lc[7:4], m_icl ? pc_i[3:0] : m_lc[3:0]};
                default: r = {1'b1, m_ma, m_ia, m_icu, m_mb, m_ib, m_icl};
            endcase
        end
        return r;
    endfunction

    // reference model update and every-cycle comparison
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ma = 2'b00; m_mb = 1'b0;
            m_ia = 1'b1; m_icu = 1'b1; m_ib = 1'b1; m_icl = 1'b1;
            m_la = 8'h00; m_lb = 8'h00; m_lc = 8'h00;
        end else if (bus_cs && bus_wr) begin
            case (bus_addr)
                2'd0: m_la = bus_wdata;
                2'd1: m_lb = bus_wdata;
                2'd2: m_lc = bus_wdata;
                default: begin
                    if (bus_wdata[7]) begin
                        m_ma = bus_wdata[6:5]; m_ia = bus_wdata[4]; m_icu = bus_wdata[3];
                        m_mb = bus_wdata[2];   m_ib = bus_wdata[1]; m_icl = bus_wdata[0];
                        m_la = 8'h00; m_lb = 8'h00; m_lc = 8'h00;
                    end else begin
                        m_lc[bus_wdata[3:1]] = bus_wdata[0];
                    end
                end
            endcase
        end
        #1;
        check("R2 R4 pa_o", pa_o, m_la);
        check("R2 R4 pb_o", pb_o, m_lb);
        check("R2 R5 pc_o", pc_o, m_lc);
        check("R3 pa_oe", pa_oe, {8{~m_ia}});
        check("R3 pb_oe", pb_oe, {8{~m_ib}});
        check("R3 pc_oe", pc_oe, {{4{~m_icu}}, {4{~m_icl}}});
        check("R7 R8 R10 rdata", bus_rdata, model_rd());
    end

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input logic cs);
        @(negedge clk);
        bus_cs = cs; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_cs = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_cs = 1'b1; bus_rd = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        bus_cs = 1'b0; bus_rd = 1'b0;
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        check("R1 pa_oe in reset", pa_oe, 8'h00);
        check("R1 pc_o in reset", pc_o, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        bus_read(2'd3, v);
        check("R1 cfg after reset", v, 8'h9B);

        bus_write(2'd3, 8'h80, 1'b1);
        check("R3 all outputs", pa_oe & pb_oe & pc_oe, 8'hFF);
        bus_write(2'd0, 8'h5A, 1'b1);
        bus_write(2'd1, 8'hC3, 1'b1);
        bus_write(2'd2, 8'h96, 1'b1);
        check("R2 port A", pa_o, 8'h5A);
        check("R2 port B", pb_o, 8'hC3);
        check("R2 port C", pc_o, 8'h96);
        pa_i = 8'h11;
        bus_read(2'd0, v);
        check("R7 output port reads latch", v, 8'h5A);

        bus_write(2'd3, 8'h80, 1'b1);
        check("R4 latches cleared", pa_o | pb_o | pc_o, 8'h00);

        bus_write(2'd3, 8'h0F, 1'b1);
        check("R5 set bit 7", pc_o, 8'h80);
        bus_write(2'd3, 8'h07, 1'b1);
        check("R5 set bit 3", pc_o, 8'h88);
        bus_write(2'd3, 8'h0E, 1'b1);
        check("R5 clear bit 7", pc_o, 8'h08);
        bus_write(2'd3, 8'h71, 1'b1);
        check("R6 bits 6:4 ignored", pc_o, 8'h09);
        bus_read(2'd3, v);
        check("R6 cfg unchanged", v, 8'h80);

        bus_write(2'd0, 8'hFF, 1'b0);
        bus_write(2'd3, 8'h9B, 1'b0);
        check("R9 no write without cs", pa_o, 8'h00);
        check("R9 cfg kept without cs", pa_oe, 8'hFF);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 2'd3;
        #1 check("R9 no read without cs", bus_rdata, 8'h00);
        bus_rd = 1'b0;

        bus_write(2'd3, 8'h8A, 1'b1);
        check("R3 mixed pc_oe", pc_oe, 8'h0F);
        check("R3 pb input", pb_oe, 8'h00);
        pc_i = 8'hA5; pb_i = 8'h77;
        bus_read(2'd2, v);
        check("R7 C nibbles after clear", v, 8'hA0);
        bus_write(2'd2, 8'h3C, 1'b1);
        bus_read(2'd2, v);
        check("R7 C mixed nibbles", v, 8'hAC);
        bus_read(2'd1, v);
        check("R7 input port reads pins", v, 8'h77);
        bus_read(2'd3, v);
        check("R8 cfg readback", v, 8'h8A);

        bus_write(2'd3, 8'hE4, 1'b1);
        bus_read(2'd3, v);
        check("R8 modes readback", v, 8'hE4);
        @(negedge clk);
        check("R10 idle rdata", bus_rdata, 8'h00);

        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            bus_cs = $urandom_range(0, 3) != 0;
            bus_wr = $urandom_range(0, 1);
            bus_rd = $urandom_range(0, 1);
            bus_addr = 2'($urandom_range(0, 3));
            bus_wdata = 8'($urandom);
            pa_i = 8'($urandom); pb_i = 8'($urandom); pc_i = 8'($urandom);
        end
        @(negedge clk);
        bus_cs = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule